// File: doc/BRIEF.md
# 1-Wire Reset and Presence Sequencer

This block produces the reset pulse and presence-detect window of a 1-Wire bus on an open-drain line. A one-cycle start strobe launches a cycle: the block holds the line low for the reset period and then releases it. While the line is released it samples the line twice: once early, to catch a line that never came back up (a short), and once later, to catch a slave's presence pulse. The cycle ends when the reset high time has elapsed. Both standard and overdrive speeds are supported. The speed is chosen by an input that is captured when the cycle is launched.

At standard speed the block can optionally hide the fast falling edge of a slave's presence pulse. To do this it pulls the line low itself, from shortly after release until partway into the presence window, so the slave takes over a line that is already low. This masking is never applied at overdrive.

All timing is counted in clock cycles. It is derived from the parameter `CLK_PER_US`, which must be a multiple of 4 because some intervals are quarter-microsecond multiples. The block has no data stream, so every pin is a plain control or status signal. The caller drives a pad with `pull_low` and feeds back the level it samples on `line_in`.

Top module: `ow_reset_presence`

## Requirements
- R1: After reset, `pull_low`, `busy`, `presence` and `short_det` are all 0.
- R2: A `start` seen high on an edge while `busy` is 0 launches a cycle. From that edge, `busy` and `pull_low` are 1, and `pull_low` stays 1 for exactly 600 µs × `CLK_PER_US` cycles at standard speed (`overdrive`=0), or 72 µs × `CLK_PER_US` at overdrive (`overdrive`=1).
- R3: `busy` stays 1 for the reset-low time plus the reset-high time: 600+584 µs at standard speed, or 72+74 µs at overdrive. It then returns to 0.
- R4: On the edge that ends the cycle 70 µs after release (standard) or 7.5 µs after release (overdrive), `presence` is loaded with the inverse of `line_in`. A low line sets it and a high line clears it.
- R5: On the edge that ends the cycle 8 µs after release (standard) or 0.75 µs after release (overdrive), `short_det` is loaded with the inverse of `line_in`.
- R6: With `mask_en`=1 at launch and standard speed, `pull_low` is 1 again from 10 µs after release until 60 µs after release, end exclusive. Outside the reset-low and mask periods it is 0.
- R7: With `overdrive`=1 at launch, `mask_en` has no effect on `pull_low`.
- R8: While `busy` is 1, `start`, `overdrive` and `mask_en` are ignored. The running cycle keeps its timing and waveform.
- R9: Both flags are cleared on the launch edge. They then hold their value until the next launch, including after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, acted on only when idle |
| overdrive | input | 1 | 1 selects overdrive timing, captured at launch |
| mask_en | input | 1 | 1 enables presence-edge masking, captured at launch |
| line_in | input | 1 | Sampled level of the 1-Wire line |
| pull_low | output | 1 | 1 drives the open-drain line low |
| busy | output | 1 | Cycle in progress |
| presence | output | 1 | Presence was seen in the last cycle |
| short_det | output | 1 | Line was still low at the short-sample point |

## Verification
The assertions assume that `line_in` is already synchronous to `clk` and stable around each rising edge. They also assume that `start`, `overdrive` and `mask_en` are driven synchronously, with no meaning attached to their values before reset is released. The bench changes every input only at falling edges. It derives `line_in` as the wired-AND of the design's own pulldown and a modelled slave pulldown, so the line level is settled well before the edge that samples it. Deliberate pokes of `start`, `overdrive` and `mask_en` during a cycle are also placed on falling edges. This exercises the ignore rule without creating races at the edge.

// File: rtl/ow_rst_pkg.sv
package ow_rst_pkg;
  // Intervals in quarter-microsecond units
  localparam int unsigned Q_STD_LOW  = 2400;
  localparam int unsigned Q_STD_HIGH = 2336;
  localparam int unsigned Q_STD_SHRT = 32;
  localparam int unsigned Q_STD_PRES = 280;
  localparam int unsigned Q_STD_MSK0 = 40;
  localparam int unsigned Q_STD_MSK1 = 240;
  localparam int unsigned Q_OD_LOW   = 288;
  localparam int unsigned Q_OD_HIGH  = 296;
  localparam int unsigned Q_OD_SHRT  = 3;
  localparam int unsigned Q_OD_PRES  = 30;

  function automatic int unsigned q2clk(input int unsigned q, input int unsigned cpu);
    return (q * cpu) / 4;
  endfunction
endpackage

// File: rtl/ow_rst_timer.sv
module ow_rst_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [CW-1:0] last,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: cycle ends right after the final count
  p_cycle_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt == last) && !launch |=> !busy);
  // R3: count never stalls while busy
  p_count_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != last) |=> busy && (cnt != $past(cnt)));
endmodule

// File: rtl/ow_rst_window.sv
module ow_rst_window #(
  parameter int CW = 16
) (
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic          act
);
  always_comb act = en && (cnt >= lo) && (cnt < hi);
endmodule

// File: rtl/ow_rst_sampler.sv
module ow_rst_sampler #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          busy,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] at,
  input  logic          line,
  output logic          flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag <= 1'b0;
    else if (clr)                 flag <= 1'b0;
    else if (busy && cnt == at)   flag <= ~line;
  end

  // R9: launch clears the flag
  p_clear_at_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
  // R9: flag holds while idle
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !clr |=> $stable(flag));
endmodule

// File: rtl/ow_reset_presence.sv
module ow_reset_presence #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic overdrive,
  input  logic mask_en,
  input  logic line_in,
  output logic pull_low,
  output logic busy,
  output logic presence,
  output logic short_det
);
  import ow_rst_pkg::*;

  localparam int unsigned TOTAL = q2clk(Q_STD_LOW + Q_STD_HIGH, CLK_PER_US);
  localparam int          CW    = $clog2(TOTAL + 1);

  localparam logic [CW-1:0] S_LOW  = CW'(q2clk(Q_STD_LOW,  CLK_PER_US));
  localparam logic [CW-1:0] S_HIGH = CW'(q2clk(Q_STD_HIGH, CLK_PER_US));
  localparam logic [CW-1:0] S_SHRT = CW'(q2clk(Q_STD_SHRT, CLK_PER_US));
  localparam logic [CW-1:0] S_PRES = CW'(q2clk(Q_STD_PRES, CLK_PER_US));
  localparam logic [CW-1:0] S_MSK0 = CW'(q2clk(Q_STD_MSK0, CLK_PER_US));
  localparam logic [CW-1:0] S_MSK1 = CW'(q2clk(Q_STD_MSK1, CLK_PER_US));
  localparam logic [CW-1:0] O_LOW  = CW'(q2clk(Q_OD_LOW,   CLK_PER_US));
  localparam logic [CW-1:0] O_HIGH = CW'(q2clk(Q_OD_HIGH,  CLK_PER_US));
  localparam logic [CW-1:0] O_SHRT = CW'(q2clk(Q_OD_SHRT,  CLK_PER_US));
  localparam logic [CW-1:0] O_PRES = CW'(q2clk(Q_OD_PRES,  CLK_PER_US));

  logic          od_l, mask_l, launch;
  logic [CW-1:0] cnt, t_low, t_last, t_shrt, t_pres;
  logic          low_act, mask_act;

  assign launch = start && !busy;

  // Speed and mask are captured once per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_l   <= 1'b0;
      mask_l <= 1'b0;
    end else if (launch) begin
      od_l   <= overdrive;
      mask_l <= mask_en;
    end
  end

  always_comb begin
    t_low  = od_l ? O_LOW : S_LOW;
    t_last = od_l ? (O_LOW + O_HIGH - 1'b1) : (S_LOW + S_HIGH - 1'b1);
    t_shrt = od_l ? (O_LOW + O_SHRT) : (S_LOW + S_SHRT);
    t_pres = od_l ? (O_LOW + O_PRES) : (S_LOW + S_PRES);
  end

  ow_rst_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .last(t_last),
    .busy(busy), .cnt(cnt)
  );

  ow_rst_window #(.CW(CW)) u_win_low (
    .en(busy), .cnt(cnt), .lo('0), .hi(t_low), .act(low_act)
  );

  ow_rst_window #(.CW(CW)) u_win_mask (
    .en(busy && mask_l && !od_l), .cnt(cnt),
    .lo(S_LOW + S_MSK0), .hi(S_LOW + S_MSK1), .act(mask_act)
  );

  assign pull_low = low_act | mask_act;

  ow_rst_sampler #(.CW(CW)) u_smp_short (
    .clk(clk), .rst_n(rst_n), .clr(launch), .busy(busy), .cnt(cnt),
    .at(t_shrt), .line(line_in), .flag(short_det)
  );

  ow_rst_sampler #(.CW(CW)) u_smp_pres (
    .clk(clk), .rst_n(rst_n), .clr(launch), .busy(busy), .cnt(cnt),
    .at(t_pres), .line(line_in), .flag(presence)
  );

  // R2: a launch drives the line low on the next cycle
  p_launch_pulls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && pull_low);
  // R6: the line is only ever driven during a cycle
  p_pull_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> busy);
  // R7: no drive after release at overdrive
  p_od_no_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && od_l && (cnt >= O_LOW) |-> !pull_low);
  // R8: a start while busy does not restart the count or change the mode
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && (cnt != t_last) |=> busy && (cnt != '0) && $stable(od_l) && $stable(mask_l));
endmodule

// File: tb/tb_ow_reset_presence.sv
module tb_ow_reset_presence;
  localparam int CPU = 4;
  // Expected times in cycles at 4 clocks per microsecond
  localparam int S_LOW = 2400, S_HIGH = 2336, S_SHRT = 32, S_PRES = 280;
  localparam int S_M0 = 40, S_M1 = 240;
  localparam int O_LOW = 288, O_HIGH = 296, O_SHRT = 3, O_PRES = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, overdrive = 1'b0, mask_en = 1'b0, slave_low = 1'b0;
  logic line_in, pull_low, busy, presence, short_det;
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  assign line_in = !pull_low && !slave_low;

  ow_reset_presence #(.CLK_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .overdrive(overdrive),
    .mask_en(mask_en), .line_in(line_in), .pull_low(pull_low), .busy(busy),
    .presence(presence), .short_det(short_det)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    // R1: everything low out of reset
    check("R1 outputs after reset", {pull_low, busy, presence, short_det}, 0);
  endtask

  // Runs one cycle; the slave pulls low for s_from <= n < s_to;
  // a start plus flipped modes is poked at n == poke_n
  task automatic run(input string name, input bit od, input bit msk,
                     input int s_from, input int s_to, input int poke_n);
    int low   = od ? O_LOW : S_LOW;
    int total = od ? (O_LOW + O_HIGH) : (S_LOW + S_HIGH);
    int shrt  = low + (od ? O_SHRT : S_SHRT);
    int pres  = low + (od ? O_PRES : S_PRES);
    int bad_pull = 0, bad_busy = 0, first_pull = -1, first_busy = -1;
    bit exp_pres, exp_shrt, exp_p, exp_b;
    $display("-- %s", name);
    @(negedge clk);
    start = 1'b1; overdrive = od; mask_en = msk;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= total; n++) begin
      if (n > 0) @(negedge clk);
      slave_low = (n >= s_from) && (n < s_to);
      if (n == poke_n) begin
        start = 1'b1; overdrive = !od; mask_en = !msk;
      end else begin
        start = 1'b0; overdrive = od; mask_en = msk;
      end
      #1;
      if (n == 0) begin
        // R9: flags cleared at launch
        check("R9 flags clear at launch", {presence, short_det}, 0);
      end
      exp_p = (n < low) || (msk && !od && n >= low + S_M0 && n < low + S_M1);
      exp_b = (n < total);
      if (pull_low !== exp_p) begin
        bad_pull++; if (first_pull < 0) first_pull = n;
      end
      if (busy !== exp_b) begin
        bad_busy++; if (first_busy < 0) first_busy = n;
      end
    end
    slave_low = 1'b0; start = 1'b0;
    if (bad_pull != 0) $display("  pulldown mismatch first at cycle %0d", first_pull);
    if (bad_busy != 0) $display("  busy mismatch first at cycle %0d", first_busy);
    check("R2/R6/R7/R8 pulldown waveform mismatching cycles", bad_pull, 0);
    check("R3/R8 busy length mismatching cycles", bad_busy, 0);
    exp_pres = (pres >= s_from) && (pres < s_to);
    exp_shrt = (shrt >= s_from) && (shrt < s_to);
    repeat (3) @(negedge clk);
    check("R4 presence flag (held after cycle, R9)", presence, exp_pres);
    check("R5 short flag", short_det, exp_shrt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run("std, slave presence",           0, 0, S_LOW + 60, S_LOW + 500, -1);
    run("std, no slave",                 0, 0, -1, -1, -1);
    run("std, shorted line",             0, 0, 0, 100000, -1);
    run("std, masked, slave presence",   0, 1, S_LOW + 60, S_LOW + 500, -1);
    run("od, slave presence",            1, 0, O_LOW + 10, O_LOW + 60, -1);
    run("od, mask requested (R7)",       1, 1, O_LOW + 10, O_LOW + 60, -1);
    run("std, start poke while busy R8", 0, 0, S_LOW + 60, S_LOW + 500, 500);
    run("od, pulse ends at sample",      1, 0, O_LOW + 10, O_LOW + O_PRES, -1);
    run("od, pulse starts at sample",    1, 0, O_LOW + O_PRES, O_LOW + 80, -1);
    run("od, short boundary",            1, 0, O_LOW + O_SHRT, O_LOW + O_SHRT + 1, 40);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule